// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable ROM

This block models a 2048-word by 8-bit read-only store whose bits can each be set once and never cleared. A read begins when the active-low chip enable is seen going low. At that moment the 11-bit address is captured internally. Once the access has been open long enough, the stored word is presented, as long as the active-low output enable is also low. All timing is counted in cycles of the system clock, and both enables are sampled on that clock.

The three-state output is represented by a data bus plus a valid flag. Whenever the flag is low the data bus carries zero, which stands for high impedance. If chip enable is raised too early, the access is cut short and a one-cycle error pulse is produced. A falling chip enable that arrives too soon after the previous rise is ignored.

Programming uses the same latched address. While an access is open with output enable high and program enable low, the supplied pattern is ORed into the stored word.

Top module: `otp_latched_rom`

## Requirements
- R1: After reset every one of the 2048 words reads as 0x00.
- R2: The address is captured at the clock edge where chip enable is first sampled low. Address changes after that edge have no effect on the word returned for that access.
- R3: `dout_vld` is high only when chip enable and output enable were both sampled low at the previous edge. Whenever `dout_vld` is low, `dout` is 0x00.
- R4: Output data becomes valid at the later of two edges: the 2nd edge after the chip-enable fall edge, and the 1st edge after the output-enable fall edge.
- R5: Output data becomes invalid at the first edge where chip enable or output enable is sampled high.
- R6: If chip enable is sampled high after fewer than 3 low cycles of an accepted access, `err_abort` is high for exactly one cycle and no data is presented.
- R7: A chip-enable fall that comes after fewer than 2 high cycles is ignored. That low period presents no data and raises no error.
- R8: A clock edge with the access open, chip enable low, output enable high and program enable low ORs `prog_data` into the latched word.
- R9: Stored 1 bits are never cleared. With program enable high, or with output enable low, a programming attempt leaves the word unchanged.
- R10: Words are independent of each other. Row selection uses address bits 10..4 and column selection uses bits 3..0, and programming one address alters no other address.
- R11: During reset and right after it, `dout_vld` and `err_abort` are low and `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 11 | Word address, captured on chip-enable fall |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program enable |
| prog_data | input | 8 | Bits to set in the latched word |
| dout | output | 8 | Read data, zero when not valid |
| dout_vld | output | 1 | High when the data outputs would be driven |
| err_abort | output | 1 | One-cycle pulse on a too-short access |

## Verification
The hardest case to reach is an access that the block must refuse or cut short. One such case is a chip-enable fall that lands one cycle after a normal rise. It has to be told apart from a legal fall one cycle later, and it must raise no error when it ends. The bench produces this case by chaining a full read directly into a fall driven at the next falling clock edge. It holds the bus low for several cycles and then checks that data stays invalid and that no error appears. Aborts after one and after two low cycles are driven the same way, by raising chip enable at exactly counted edges.

// File: rtl/otp_pkg.sv
package otp_pkg;
  parameter int OTP_ADDR_W    = 11;
  parameter int OTP_DATA_W    = 8;
  parameter int OTP_COL_W     = 4;
  parameter int OTP_VALID_LAT = 2;
  parameter int OTP_MIN_LOW   = 3;
  parameter int OTP_MIN_HIGH  = 2;

  typedef enum logic {
    ACC_IDLE = 1'b0,
    ACC_OPEN = 1'b1
  } acc_state_e;
endpackage

// File: rtl/otp_edge_sense.sv
module otp_edge_sense #(
  parameter int MIN_HIGH = otp_pkg::OTP_MIN_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic ce_fall_ok,
  output logic oe_held_low
);
  localparam int HI_W = $clog2(MIN_HIGH + 1);

  logic            ce_d, ce_d_nxt;
  logic            oe_d, oe_d_nxt;
  logic [HI_W-1:0] hi_age, hi_age_nxt;

  always_comb begin
    ce_d_nxt   = ce_n;
    oe_d_nxt   = oe_n;
    hi_age_nxt = hi_age;
    if (!ce_n) begin
      hi_age_nxt = '0;
    end else if (hi_age != HI_W'(MIN_HIGH)) begin
      hi_age_nxt = hi_age + 1'b1;
    end
  end

  // fall is accepted only after enough high cycles
  assign ce_fall_ok  = ce_d & ~ce_n & (hi_age >= HI_W'(MIN_HIGH));
  assign oe_held_low = ~oe_d & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d   <= 1'b1;
      oe_d   <= 1'b1;
      hi_age <= HI_W'(MIN_HIGH);
    end else begin
      ce_d   <= ce_d_nxt;
      oe_d   <= oe_d_nxt;
      hi_age <= hi_age_nxt;
    end
  end
endmodule

// File: rtl/otp_access_fsm.sv
module otp_access_fsm
  import otp_pkg::*;
#(
  parameter int ADDR_W    = OTP_ADDR_W,
  parameter int VALID_LAT = OTP_VALID_LAT,
  parameter int MIN_LOW   = OTP_MIN_LOW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              prog_n,
  input  logic              oe_n,
  input  logic              ce_fall_ok,
  input  logic              oe_held_low,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              vld_nxt,
  output logic              vld,
  output logic              abort_pulse,
  output logic              prog_wr
);
  localparam int AGE_MAX = (MIN_LOW - 1 > VALID_LAT) ? MIN_LOW - 1 : VALID_LAT;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  acc_state_e        st, st_nxt;
  logic [AGE_W-1:0]  age, age_nxt;
  logic [ADDR_W-1:0] lat_nxt;
  logic              abort_nxt;

  always_comb begin
    st_nxt    = st;
    age_nxt   = age;
    lat_nxt   = addr_lat;
    abort_nxt = 1'b0;
    unique case (st)
      ACC_IDLE: begin
        if (ce_fall_ok) begin
          st_nxt  = ACC_OPEN;
          age_nxt = '0;
          lat_nxt = addr;
        end
      end
      ACC_OPEN: begin
        if (ce_n) begin
          st_nxt    = ACC_IDLE;
          abort_nxt = (age < AGE_W'(MIN_LOW - 1));
        end else if (age != AGE_W'(AGE_MAX)) begin
          age_nxt = age + 1'b1;
        end
      end
      default: st_nxt = ACC_IDLE;
    endcase
    vld_nxt = (st_nxt == ACC_OPEN) && (age_nxt >= AGE_W'(VALID_LAT))
              && oe_held_low && prog_n;
  end

  assign prog_wr = (st == ACC_OPEN) && !ce_n && !prog_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ACC_IDLE;
      age         <= '0;
      addr_lat    <= '0;
      vld         <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      st          <= st_nxt;
      age         <= age_nxt;
      addr_lat    <= lat_nxt;
      vld         <= vld_nxt;
      abort_pulse <= abort_nxt;
    end
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
#(
  parameter int ADDR_W = OTP_ADDR_W,
  parameter int DATA_W = OTP_DATA_W,
  parameter int COL_W  = OTP_COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] wr_bits,
  output logic [DATA_W-1:0] rd_word
);
  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int ROWS     = 1 << ROW_W;
  localparam int COLS     = 1 << COL_W;
  localparam int ROW_BITS = DATA_W * COLS;

  logic [ROW_BITS-1:0] cells [ROWS];
  logic [ROW_W-1:0]    row_sel;
  logic [COL_W-1:0]    col_sel;
  logic [ROW_BITS-1:0] line;

  assign row_sel = acc_addr[ADDR_W-1:COL_W];
  assign col_sel = acc_addr[COL_W-1:0];
  assign line    = cells[row_sel];

  // each output bit owns a group of COLS adjacent columns
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [COLS-1:0] grp;
    assign grp        = line[b*COLS +: COLS];
    assign rd_word[b] = grp[col_sel];
  end

  // cells only ever go from 0 to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        cells[r] <= '0;
      end
    end else if (wr_en) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (wr_bits[b]) begin
          cells[row_sel][b*COLS + int'(col_sel)] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/otp_latched_rom.sv
module otp_latched_rom
  import otp_pkg::*;
#(
  parameter int ADDR_W    = OTP_ADDR_W,
  parameter int DATA_W    = OTP_DATA_W,
  parameter int COL_W     = OTP_COL_W,
  parameter int VALID_LAT = OTP_VALID_LAT,
  parameter int MIN_LOW   = OTP_MIN_LOW,
  parameter int MIN_HIGH  = OTP_MIN_HIGH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_n,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              err_abort
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              ce_fall_ok;
  logic              oe_held_low;
  logic [ADDR_W-1:0] addr_lat;
  logic              vld_nxt;
  logic              prog_wr;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] dout_q, dout_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  otp_edge_sense #(.MIN_HIGH(MIN_HIGH)) u_edge (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .ce_fall_ok (ce_fall_ok),
    .oe_held_low(oe_held_low)
  );

  otp_access_fsm #(
    .ADDR_W   (ADDR_W),
    .VALID_LAT(VALID_LAT),
    .MIN_LOW  (MIN_LOW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ce_n       (ce_n),
    .prog_n     (prog_n),
    .oe_n       (oe_n),
    .ce_fall_ok (ce_fall_ok),
    .oe_held_low(oe_held_low),
    .addr       (addr),
    .addr_lat   (addr_lat),
    .vld_nxt    (vld_nxt),
    .vld        (dout_vld),
    .abort_pulse(err_abort),
    .prog_wr    (prog_wr)
  );

  otp_fuse_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .COL_W (COL_W)
  ) u_arr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (prog_wr),
    .acc_addr(addr_lat),
    .wr_bits (prog_data),
    .rd_word (rd_word)
  );

  always_comb begin
    dout_nxt = vld_nxt ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      dout_q <= '0;
    end else begin
      dout_q <= dout_nxt;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/otp_latched_rom_chk.sv
module otp_latched_rom_chk #(
  parameter int DATA_W = otp_pkg::OTP_DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld,
  input logic              err_abort
);
  // R3
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> dout == '0);

  // R3
  vld_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> ($past(ce_n) == 1'b0 && $past(oe_n) == 1'b0));

  // R5
  enable_rise_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> !dout_vld);

  // R6
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |=> !err_abort);

  // R6
  abort_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |-> ($past(ce_n) == 1'b1 && !dout_vld));

  // R2
  held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && $past(dout_vld)) |-> $stable(dout));
endmodule

bind otp_latched_rom otp_latched_rom_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .dout     (dout),
  .dout_vld (dout_vld),
  .err_abort(err_abort)
);

// File: tb/sim_otp_latched_rom.sv
module sim_otp_latched_rom;
  logic        clk;
  logic        rst_n;
  logic [10:0] addr;
  logic        ce_n;
  logic        oe_n;
  logic        prog_n;
  logic [7:0]  prog_data;
  logic [7:0]  dout;
  logic        dout_vld;
  logic        err_abort;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  otp_latched_rom u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .prog_n   (prog_n),
    .prog_data(prog_data),
    .dout     (dout),
    .dout_vld (dout_vld),
    .err_abort(err_abort)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pat_a(int a);
    return 8'((a * 29 + 7) ^ (a >> 5));
  endfunction

  function automatic logic [7:0] pat_b(int a);
    return 8'((a * 3) ^ (a >> 4)) & 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // full read: fall, two waits, sample, rise, idle
  task automatic do_read(input logic [10:0] a, input logic [7:0] expv, input string req);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); addr = ~a;
    chk(dout_vld == 1'b0, "R4 early", int'(dout_vld), 0);
    @(negedge clk);
    chk(dout_vld == 1'b0, "R4 early", int'(dout_vld), 0);
    @(negedge clk);
    chk(dout_vld == 1'b1 && dout == expv, req, int'({dout_vld, dout}), int'({1'b1, expv}));
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk(dout_vld == 1'b0 && dout == 8'h00 && err_abort == 1'b0, "R5 R3 end",
        int'({err_abort, dout_vld, dout}), 0);
    @(negedge clk);
  endtask

  task automatic do_prog(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b1; prog_n = 1'b1;
    @(negedge clk); addr = ~a; prog_n = 1'b0; prog_data = d;
    @(negedge clk); prog_n = 1'b1; prog_data = 8'h00;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_n = 1'b1; prog_n = 1'b1; prog_data = '0;
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(dout_vld == 0 && err_abort == 0 && dout == 0, "R11 in reset",
        int'({err_abort, dout_vld, dout}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_vld == 0 && err_abort == 0 && dout == 0, "R11 after reset",
        int'({err_abort, dout_vld, dout}), 0);

    // R1 R2 R10: every word blank
    for (int a = 0; a < 2048; a++) do_read(11'(a), 8'h00, "R1 blank word");
    // R8 then R9 OR of a second pattern
    for (int a = 0; a < 2048; a++) do_prog(11'(a), pat_a(a));
    for (int a = 0; a < 2048; a++) do_prog(11'(a), pat_b(a));
    // R10 R9 readback across all rows and columns
    for (int a = 0; a < 2048; a++) do_read(11'(a), pat_a(a) | pat_b(a), "R10 R9 readback");

    // R9: attempt with prog_n high, attempt with oe low, program zeros
    @(negedge clk); addr = 11'd5; ce_n = 0; oe_n = 1; prog_n = 1; prog_data = 8'hFF;
    repeat (3) @(negedge clk); ce_n = 1; prog_data = 8'h00;
    repeat (2) @(negedge clk);
    @(negedge clk); addr = 11'd5; ce_n = 0; oe_n = 0; prog_n = 0; prog_data = 8'hFF;
    repeat (3) @(negedge clk);
    chk(dout_vld == 0, "R9 no output while programming", int'(dout_vld), 0);
    ce_n = 1; oe_n = 1; prog_n = 1; prog_data = 8'h00;
    repeat (2) @(negedge clk);
    do_prog(11'd5, 8'h00);
    do_read(11'd5, pat_a(5) | pat_b(5), "R9 unchanged");

    // R4 late output enable, R5 output-enable and chip-enable rise
    @(negedge clk); addr = 11'd300; ce_n = 0; oe_n = 1;
    @(negedge clk); addr = 11'd0;
    @(negedge clk);
    @(negedge clk);
    chk(dout_vld == 0, "R4 oe still high", int'(dout_vld), 0);
    oe_n = 0;
    @(negedge clk);
    chk(dout_vld == 0, "R4 one edge after oe fall", int'(dout_vld), 0);
    @(negedge clk);
    chk(dout_vld == 1 && dout == (pat_a(300) | pat_b(300)), "R4 late oe data",
        int'({dout_vld, dout}), int'({1'b1, pat_a(300) | pat_b(300)}));
    oe_n = 1;
    @(negedge clk);
    chk(dout_vld == 0 && dout == 0, "R5 oe rise", int'({dout_vld, dout}), 0);
    oe_n = 0;
    @(negedge clk);
    chk(dout_vld == 0, "R4 oe refall", int'(dout_vld), 0);
    @(negedge clk);
    chk(dout_vld == 1 && dout == (pat_a(300) | pat_b(300)), "R2 R4 reopen keeps address",
        int'({dout_vld, dout}), int'({1'b1, pat_a(300) | pat_b(300)}));
    ce_n = 1;
    @(negedge clk);
    chk(dout_vld == 0 && err_abort == 0, "R5 ce rise", int'({err_abort, dout_vld}), 0);
    oe_n = 1;
    repeat (2) @(negedge clk);

    // R6 abort after one low cycle
    @(negedge clk); addr = 11'd7; ce_n = 0; oe_n = 0;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    chk(err_abort == 1 && dout_vld == 0, "R6 abort 1 cycle", int'({err_abort, dout_vld}), 2);
    @(negedge clk);
    chk(err_abort == 0, "R6 pulse width", int'(err_abort), 0);
    @(negedge clk);
    // R6 abort after two low cycles
    @(negedge clk); ce_n = 0;
    @(negedge clk);
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    chk(err_abort == 1 && dout_vld == 0, "R6 abort 2 cycles", int'({err_abort, dout_vld}), 2);
    @(negedge clk);
    chk(err_abort == 0, "R6 pulse width", int'(err_abort), 0);
    oe_n = 1;
    repeat (2) @(negedge clk);

    // R7 fall one cycle after a rise is ignored
    @(negedge clk); addr = 11'd9; ce_n = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    chk(dout_vld == 1, "R7 setup read", int'(dout_vld), 1);
    ce_n = 1;
    @(negedge clk); ce_n = 0; addr = 11'd10;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(dout_vld == 0 && err_abort == 0, "R7 ignored fall", int'({err_abort, dout_vld}), 0);
    end
    ce_n = 1;
    @(negedge clk);
    chk(err_abort == 0, "R7 no error at end", int'(err_abort), 0);
    oe_n = 1;
    @(negedge clk);
    do_read(11'd10, pat_a(10) | pat_b(10), "R7 next legal read");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule